// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (2 kbit)

This block behaves as a 2-kbit serial EEPROM sitting on a two-wire (I2C-style) bus. It runs from a fast system clock and oversamples the bus clock and data lines. Each line passes through a synchronizer and a glitch filter. The filtered lines drive a slave engine that recognises start and stop conditions, shifts bytes in most significant bit first, and pulls the data line low on the ninth clock of every byte it accepts. The same engine shifts bytes out for reads.

The storage is 256 bytes, seen as 16 pages of 16 bytes, and every access is addressed by a single word-address byte. A write first collects its bytes in a one-page buffer. When the stop condition arrives, a timed internal write cycle starts and the buffer is copied into the array. While that cycle runs the device ignores its own bus address, so a master can poll for completion by retrying the address until it is acknowledged.

The device address is a 7-bit parameter sent ahead of a direction bit: bit 0 of the first byte is 1 for read and 0 for write. A random read is a write of the word address, then a repeated start, then a read.

Top module: `eep_two_wire_slave`

## Requirements
- R1: Bytes clocked on the bus with no start condition in front of them are ignored: none of them is acknowledged.
- R2: After reset, and after a stop condition, the block leaves the data line released, and bytes that follow without a new start are not acknowledged.
- R3: The block changes its data-line drive only while the bus clock is low, except when it releases the line on a start or stop.
- R4: After a start, a first byte whose upper seven bits equal the device address is acknowledged by a low data line during the ninth clock. A mismatching address gets no acknowledge. Word-address and write-data bytes are always acknowledged.
- R5: A random read returns the byte stored at the word address last written, shifted out most significant bit first.
- R6: After a stop that ends a write carrying at least one data byte, the device address is not acknowledged for WR_CYCLES system clocks. After that it is acknowledged again.
- R7: A pulse on either bus line that lasts fewer than FILT_LEN system clocks is ignored. It is neither a start condition nor a clock edge.
- R8: During a write, the low four address bits advance after each data byte and wrap within the current 16-byte page, and the upper four bits stay fixed. Bytes of the page that were not written keep their old value.
- R9: A sequential read advances the address by one per byte across the whole array, wrapping from 0xFF to 0x00.
- R10: When the master does not acknowledge a read byte, the block releases the data line and sends nothing more until a new start.
- R11: After reset every location reads 0xFF.
- R12: A start in the middle of a byte discards the partial byte and restarts device-address reception. The stored word address is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
The bench builds the block with FILT_LEN = 2 and a write cycle shortened to 300 clocks, so that eight full page writes, each followed by a busy poll, fit in the run. The bus quarter-period is 6 system clocks. This setting makes single-cycle glitches land below the filter threshold while real edges pass. With a 256-byte array, one sequential read covers every location, including the wrap from 0xFF to 0x00, so the exact contents of written, partially written and erased pages are checked arithmetically against a model.

// File: rtl/eep_pkg.sv
package eep_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WADDR,
      ST_WADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } eep_state_e;

   localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/eep_line_filter.sv
module eep_line_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   raw_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   assign raw_s = sync_q[SYNC_STAGES-1];

   generate
      if (FILT_LEN == 0) begin : g_bypass
         assign line_o = raw_s;
      end else begin : g_filter
         localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
         logic [CNT_W-1:0] cnt_q;
         logic             out_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               out_q <= 1'b1;
            end else if (raw_s != out_q) begin
               if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
                  out_q <= raw_s;
                  cnt_q <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end else begin
               cnt_q <= '0;
            end
         end

         assign line_o = out_q;

         AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
            (out_q != $past(out_q)) |-> ($past(raw_s) == out_q)); // R7
      end
   endgenerate

endmodule

// File: rtl/eep_mem_core.sv
module eep_mem_core #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned PAGE_W    = 4,
   parameter int unsigned WR_CYCLES = 250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data,
   input  logic              buf_we,
   input  logic [ADDR_W-1:0] buf_addr,
   input  logic [7:0]        buf_data,
   input  logic              commit,
   output logic              busy
);

   localparam int unsigned DEPTH      = 1 << ADDR_W;
   localparam int unsigned PAGE_BYTES = 1 << PAGE_W;
   localparam int unsigned PG_W       = ADDR_W - PAGE_W;
   localparam int unsigned TMR_W      = $clog2(WR_CYCLES + 1);

   logic [7:0]            mem_q  [DEPTH];
   logic [7:0]            pbuf_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] valid_q;
   logic [PG_W-1:0]       page_q;
   logic                  pend_q;
   logic [TMR_W-1:0]      tmr_q;
   logic                  busy_q;

   assign rd_data = mem_q[rd_addr];
   assign busy    = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= 8'hFF;
         valid_q <= '0;
         page_q  <= '0;
         pend_q  <= 1'b0;
      end else if (buf_we) begin
         pbuf_q[buf_addr[PAGE_W-1:0]]  <= buf_data;
         valid_q[buf_addr[PAGE_W-1:0]] <= 1'b1;
         page_q <= buf_addr[ADDR_W-1:PAGE_W];
         pend_q <= 1'b1;
      end else if (busy_q && tmr_q == '0) begin
         valid_q <= '0;
         pend_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tmr_q  <= '0;
      end else if (commit) begin
         busy_q <= 1'b1;
         tmr_q  <= TMR_W'(WR_CYCLES - 1);
      end else if (busy_q) begin
         if (tmr_q == '0) busy_q <= 1'b0;
         else             tmr_q  <= tmr_q - TMR_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
      end else if (busy_q && tmr_q == '0) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (valid_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= pbuf_q[i];
         end
      end
   end

   AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (tmr_q < TMR_W'(WR_CYCLES))); // R6
   AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !busy_q); // R6
   AST_NO_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !buf_we); // R6
   AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_we && pend_q) |-> (buf_addr[ADDR_W-1:PAGE_W] == page_q)); // R8

endmodule

// File: rtl/eep_bus_engine.sv
module eep_bus_engine
   import eep_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR = 7'h50,
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned PAGE_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_f,
   input  logic              sda_f,
   input  logic              busy,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              buf_we,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [7:0]        buf_data,
   output logic              commit,
   output logic              sda_pull
);

   eep_state_e        state_q;
   logic              scl_d, sda_d;
   logic              start_det, stop_det, scl_rise, scl_fall;
   logic [3:0]        bitcnt_q;
   logic [7:0]        shreg_q;
   logic [ADDR_W-1:0] addr_q;
   logic              rw_q, mack_q, wpend_q, pull_q;
   logic              byte_done;

   assign start_det = scl_f & scl_d & sda_d & ~sda_f;
   assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
   assign scl_rise  = scl_f & ~scl_d;
   assign scl_fall  = ~scl_f & scl_d;
   assign byte_done = scl_fall && (bitcnt_q == 4'd8);
   assign rd_addr   = addr_q;
   assign sda_pull  = pull_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_f;
         sda_d <= sda_f;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         addr_q   <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         wpend_q  <= 1'b0;
         pull_q   <= 1'b0;
         buf_we   <= 1'b0;
         buf_addr <= '0;
         buf_data <= '0;
         commit   <= 1'b0;
      end else begin
         buf_we <= 1'b0;
         commit <= 1'b0;
         if (start_det) begin
            state_q  <= ST_DEV;
            bitcnt_q <= '0;
            pull_q   <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            pull_q  <= 1'b0;
            if (wpend_q) begin
               commit  <= 1'b1;
               wpend_q <= 1'b0;
            end
         end else begin
            unique case (state_q)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise) begin
                     shreg_q  <= {shreg_q[6:0], sda_f};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else if (byte_done) begin
                     if (state_q == ST_DEV) begin
                        if (shreg_q[7:1] == DEV_ADDR && !busy) begin
                           rw_q    <= shreg_q[0];
                           pull_q  <= 1'b1;
                           state_q <= ST_DEV_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else if (state_q == ST_WADDR) begin
                        addr_q  <= shreg_q[ADDR_W-1:0];
                        pull_q  <= 1'b1;
                        state_q <= ST_WADDR_ACK;
                     end else begin
                        buf_we   <= 1'b1;
                        buf_addr <= addr_q;
                        buf_data <= shreg_q;
                        addr_q   <= {addr_q[ADDR_W-1:PAGE_W],
                                     addr_q[PAGE_W-1:0] + PAGE_W'(1)};
                        wpend_q  <= 1'b1;
                        pull_q   <= 1'b1;
                        state_q  <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_DEV_ACK: begin
                  if (scl_fall) begin
                     bitcnt_q <= '0;
                     if (rw_q) begin
                        shreg_q <= rd_data;
                        pull_q  <= ~rd_data[7];
                        state_q <= ST_RDATA;
                     end else begin
                        pull_q  <= 1'b0;
                        state_q <= ST_WADDR;
                     end
                  end
               end
               ST_WADDR_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     pull_q   <= 1'b0;
                     bitcnt_q <= '0;
                     state_q  <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise) begin
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end else if (byte_done) begin
                     pull_q  <= 1'b0;
                     addr_q  <= addr_q + ADDR_W'(1);
                     state_q <= ST_RACK;
                  end else if (scl_fall) begin
                     shreg_q <= {shreg_q[6:0], 1'b0};
                     pull_q  <= ~shreg_q[6];
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_f;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        shreg_q  <= rd_data;
                        pull_q   <= ~rd_data[7];
                        bitcnt_q <= '0;
                        state_q  <= ST_RDATA;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   AST_PULL_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(scl_f) && $past(scl_f, 2) && !$past(start_det || stop_det))
         |-> $stable(pull_q)); // R3
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !pull_q); // R10
   AST_ACK_AFTER_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pull_q) && (state_q == ST_DEV_ACK || state_q == ST_WADDR_ACK ||
                         state_q == ST_WDATA_ACK)) |-> ($past(bitcnt_q) == 4'd8)); // R4
   AST_BUSY_NO_DEV_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEV_ACK && $past(state_q) != ST_DEV_ACK) |-> !$past(busy)); // R6

endmodule

// File: rtl/eep_two_wire_slave.sv
module eep_two_wire_slave #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FILT_LEN    = 3,
   parameter int unsigned WR_CYCLES   = 250000,
   parameter logic [6:0]  DEV_ADDR    = 7'h50,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned PAGE_W      = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_pull_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ADDR_W > 8 || ADDR_W < 2) begin : g_chk_addr
         $error("ADDR_W must lie in 2..8, the word address is one byte");
      end
      if (PAGE_W == 0 || PAGE_W >= ADDR_W) begin : g_chk_page
         $error("PAGE_W must lie in 1..ADDR_W-1");
      end
      if (WR_CYCLES == 0) begin : g_chk_wr
         $error("WR_CYCLES must be at least 1");
      end
   endgenerate

   logic              scl_f, sda_f, busy;
   logic [7:0]        rd_data, buf_data;
   logic [ADDR_W-1:0] rd_addr, buf_addr;
   logic              buf_we, commit;

   eep_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_scl_filt (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));

   eep_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) i_sda_filt (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

   eep_bus_engine #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_engine (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .busy(busy),
      .rd_data(rd_data), .rd_addr(rd_addr), .buf_we(buf_we), .buf_addr(buf_addr),
      .buf_data(buf_data), .commit(commit), .sda_pull(sda_pull_o));

   eep_mem_core #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) i_mem (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .commit(commit), .busy(busy));

endmodule

// File: tb/test_eep_two_wire_slave.sv
`timescale 1ns/1ps
module test_eep_two_wire_slave;

   localparam int WRC = 300;
   localparam int Q   = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic sda_m = 1'b1;
   logic drv;
   logic sda_line;
   int   checks = 0;
   int   errors = 0;
   int   r3_viol = 0;
   logic prev_drv = 1'b0;
   logic prev_scl = 1'b1;
   logic [7:0] model [256];

   assign sda_line = sda_m & ~drv;

   always #10 clk = ~clk;

   eep_two_wire_slave #(.SYNC_STAGES(2), .FILT_LEN(2), .WR_CYCLES(WRC),
                        .DEV_ADDR(7'h50), .ADDR_W(8), .PAGE_W(4)) i_eep_two_wire_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(drv));

   // R3 monitor: drive changes seen with the clock high on both samples
   always @(negedge clk) begin
      if (rst_n && drv !== prev_drv && scl && prev_scl) r3_viol++;
      prev_drv <= drv;
      prev_scl <= scl;
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic start_c();
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b0; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic stop_c();
      sda_m = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      sda_m = 1'b1; tick(2 * Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q);
         if (glitch && i == 4) begin
            scl = 1'b1; tick(1); scl = 1'b0; tick(1);
         end
         scl = 1'b1; tick(2 * Q);
         scl = 1'b0; tick(Q);
      end
      sda_m = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      ack = !sda_line;
      tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(Q);
         scl = 1'b1; tick(Q);
         b[i] = sda_line;
         tick(Q);
         scl = 1'b0; tick(Q);
      end
      sda_m = !mack; tick(Q);
      scl = 1'b1;    tick(2 * Q);
      scl = 1'b0;    tick(Q);
      sda_m = 1'b1;
   endtask

   task automatic set_addr(input logic [7:0] a, input bit glitch);
      bit ack;
      start_c();
      wr_byte(8'hA0, 1'b0, ack);
      check(ack, "R4 write address ack", ack, 1);
      wr_byte(a, glitch, ack);
      check(ack, "R4 word address ack", ack, 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] rd;
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      tick(5);
      rst_n = 1'b1;
      tick(5);
      check(drv == 1'b0, "R2 released after reset", drv, 0);

      // R1: a byte with no start
      wr_byte(8'hA0, 1'b0, ack);
      check(!ack, "R1 no start no ack", ack, 0);
      scl = 1'b1; tick(2 * Q);

      // R7: one-cycle SDA dip with SCL high is not a start
      sda_m = 1'b0; tick(1); sda_m = 1'b1; tick(2 * Q);
      wr_byte(8'hA0, 1'b0, ack);
      check(!ack, "R7 glitch not a start", ack, 0);
      stop_c();

      // R4: wrong device address
      start_c();
      wr_byte(8'hA2, 1'b0, ack);
      check(!ack, "R4 mismatching address nack", ack, 0);
      stop_c();

      // R11 and R5: erased location through random read
      set_addr(8'h00, 1'b0);
      start_c();
      wr_byte(8'hA1, 1'b0, ack);
      check(ack, "R5 read address ack", ack, 1);
      rd_byte(1'b0, rd);
      check(rd == 8'hFF, "R11 erased reads FF", rd, 8'hFF);
      check(drv == 1'b0, "R10 released after master nack", drv, 0);
      stop_c();

      // R2: bytes after stop are ignored
      wr_byte(8'hA0, 1'b0, ack);
      check(!ack, "R2 no ack after stop", ack, 0);
      stop_c();

      // R12: partial byte then repeated start
      set_addr(8'h07, 1'b0);
      for (int i = 0; i < 3; i++) begin
         sda_m = 1'b0; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
      end
      start_c();
      wr_byte(8'hA1, 1'b0, ack);
      check(ack, "R12 restart accepts device address", ack, 1);
      rd_byte(1'b0, rd);
      check(rd == model[7], "R12 word address kept", rd, model[7]);
      stop_c();

      // R8 and R6: full page writes on even pages, offset wraps within page
      for (int p = 0; p < 16; p += 2) begin
         set_addr(8'((p << 4) | p), 1'b0);
         for (int k = 0; k < 16; k++) begin
            int a;
            a = (p << 4) | ((p + k) & 15);
            model[a] = pat(a);
            wr_byte(pat(a), 1'b0, ack);
            check(ack, "R4 data ack", ack, 1);
         end
         stop_c();
         start_c();
         wr_byte(8'hA0, 1'b0, ack);
         check(!ack, "R6 busy nack", ack, 0);
         stop_c();
         tick(WRC + 20);
         start_c();
         wr_byte(8'hA0, 1'b0, ack);
         check(ack, "R6 ack after write cycle", ack, 1);
         stop_c();
      end

      // R8: partial write at end of page 1 wraps to its start
      set_addr(8'h1E, 1'b0);
      for (int k = 0; k < 3; k++) begin
         int a;
         a = 16 | ((14 + k) & 15);
         model[a] = pat(a);
         wr_byte(pat(a), 1'b0, ack);
         check(ack, "R8 data ack", ack, 1);
      end
      stop_c();
      tick(WRC + 20);

      // R7: SCL glitch inside the word address byte; R5 random read
      set_addr(8'h35, 1'b1);
      start_c();
      wr_byte(8'hA1, 1'b0, ack);
      check(ack, "R7 address after scl glitch", ack, 1);
      rd_byte(1'b0, rd);
      check(rd == model[8'h35], "R5 random read", rd, model[8'h35]);
      stop_c();

      // R9: sequential read across whole array with wrap
      set_addr(8'h00, 1'b0);
      start_c();
      wr_byte(8'hA1, 1'b0, ack);
      check(ack, "R9 read address ack", ack, 1);
      for (int n = 0; n < 258; n++) begin
         rd_byte(n != 257, rd);
         check(rd == model[n & 255], "R9 sequential byte", rd, model[n & 255]);
      end
      check(drv == 1'b0, "R10 released at end of read", drv, 0);
      tick(Q);
      scl = 1'b1; tick(Q);
      check(sda_line == 1'b1, "R10 no further data", sda_line, 1);
      scl = 1'b0; tick(Q);
      stop_c();

      check(r3_viol == 0, "R3 drive changes only with clock low", r3_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule